// File: doc/BRIEF.md
# Six-Channel DAC Register Controller

This block is the bus-side control logic of a six-channel digital-to-analog output card. A byte-wide register bus with a 4-bit offset and separate read and write strobes loads each channel's 12-bit code in two bytes into an input latch. A second register per channel, the holding register, drives the DAC code bus. Reads carry no data. They act as command strobes that set the update policy. Under the immediate policy a channel updates when its high byte is written. Under the simultaneous policy all channels are copied together on command. Other read commands select a restricted output state, a hardware-triggered update, and a latched external interrupt.

A single active-low external pin serves two purposes. Its low level, while the trigger is enabled, copies every input latch into the holding registers. Its falling edge, while the interrupt is enabled, sets an interrupt flag. The restricted state is active out of reset. It forces every driven code to midscale while the holding registers keep tracking updates, and clearing it brings back the buffered codes.

Top module: `dac_bank_ctrl`

## Requirements
- R1: After reset every channel output is 0x800, `irq` is 0, the restricted state is active, the immediate policy is selected, and trigger and interrupt are disabled.
- R2: A write at even offset 2c (c = 0..5) loads bits 7:0 of channel c's input latch, and a write at odd offset 2c+1 loads bits 11:8 from data bits 3:0. Under the immediate policy a high-byte write moves the channel's full code to its output at that clock edge. A low-byte write alone never changes an output.
- R3: A read at offset 0x0 selects the simultaneous policy and a read at 0x2 selects the immediate policy. Neither read changes any output. Under the simultaneous policy, writes do not change outputs.
- R4: A read at 0x8 copies all six input latches to the outputs and selects the simultaneous policy. A read at 0xA copies them and selects the immediate policy.
- R5: A read at 0xE forces every output to 0x800 from the next clock. Updates made during the restriction still land in the holding registers. A read at 0xF makes the outputs show the holding registers again.
- R6: A read at 0x5 enables the external trigger and a read at 0x6 disables it. While it is enabled and `ext_n` is low, every clock copies all input latches to the outputs. The first copy happens at the third rising edge after `ext_n` goes low, because of two synchronising flip-flops. While the trigger is disabled, `ext_n` has no effect on the outputs.
- R7: A read at 0x3 enables the interrupt. While it is enabled, a falling edge of `ext_n` sets a flag that holds after the pin returns high. The flag is set at the third rising edge after the pin falls, and `irq` is the flag ANDed with the enable. A falling edge while the interrupt is disabled is lost.
- R8: A read at 0x4 clears both the flag and the enable. A later falling edge does not raise `irq` until 0x3 is read again.
- R9: `bus_rdata` is always 0x00. Reads at 0x1, 0x7, 0x9, 0xB, 0xC and 0xD and writes at 0xC to 0xF have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 4 | Register offset |
| bus_wdata | input | 8 | Write data byte |
| bus_wr | input | 1 | Write strobe, one access per cycle high |
| bus_rd | input | 1 | Read strobe, one command per cycle high |
| bus_rdata | output | 8 | Read data, always zero |
| ext_n | input | 1 | Shared active-low trigger and interrupt pin, asynchronous |
| dac_code | output | 72 | Channel c code at bits 12c+11 : 12c |
| irq | output | 1 | Interrupt request, active high |

## Verification
The assertions check on every cycle the properties that relate commands to the following cycle. After a restrict command all outputs read midscale. After an interrupt clear, `irq` is low. Policy selection, unused reads and low-byte writes leave the outputs unchanged. `irq` rises only after a synchronised falling edge. Only the bench scenarios can show the data path end to end: byte placement into the 12-bit code, simultaneous copies of buffered codes, the restoration of codes updated during the restriction, and the exact synchroniser latency of trigger and interrupt.

// File: rtl/dac_ctrl_pkg.sv
package dac_ctrl_pkg;

    localparam logic [3:0] OFS_SIM_ON    = 4'h0;
    localparam logic [3:0] OFS_SIM_OFF   = 4'h2;
    localparam logic [3:0] OFS_IRQ_EN    = 4'h3;
    localparam logic [3:0] OFS_IRQ_CLR   = 4'h4;
    localparam logic [3:0] OFS_TRIG_ON   = 4'h5;
    localparam logic [3:0] OFS_TRIG_OFF  = 4'h6;
    localparam logic [3:0] OFS_LOAD_SIM  = 4'h8;
    localparam logic [3:0] OFS_LOAD_IMM  = 4'hA;
    localparam logic [3:0] OFS_RSTR_ON   = 4'hE;
    localparam logic [3:0] OFS_RSTR_OFF  = 4'hF;

    typedef struct packed {
        logic sim_on;
        logic sim_off;
        logic load_sim;
        logic load_imm;
        logic irq_en;
        logic irq_clr;
        logic trig_on;
        logic trig_off;
        logic rstr_on;
        logic rstr_off;
    } rd_cmd_t;

    typedef struct packed {
        logic simul;
        logic rstr;
        logic trig_en;
        logic irq_en;
        logic irq_flag;
    } mode_t;

endpackage

// File: rtl/dac_rd_decode.sv
module dac_rd_decode
    import dac_ctrl_pkg::*;
#(
    parameter int AW = 4
) (
    input  logic          rd,
    input  logic [AW-1:0] addr,
    output rd_cmd_t       cmd
);

    always_comb begin
        cmd = '0;
        if (rd) begin
            case (addr)
                OFS_SIM_ON:   cmd.sim_on   = 1'b1;
                OFS_SIM_OFF:  cmd.sim_off  = 1'b1;
                OFS_IRQ_EN:   cmd.irq_en   = 1'b1;
                OFS_IRQ_CLR:  cmd.irq_clr  = 1'b1;
                OFS_TRIG_ON:  cmd.trig_on  = 1'b1;
                OFS_TRIG_OFF: cmd.trig_off = 1'b1;
                OFS_LOAD_SIM: cmd.load_sim = 1'b1;
                OFS_LOAD_IMM: cmd.load_imm = 1'b1;
                OFS_RSTR_ON:  cmd.rstr_on  = 1'b1;
                OFS_RSTR_OFF: cmd.rstr_off = 1'b1;
                default:      cmd = '0;
            endcase
        end
    end

endmodule

// File: rtl/dac_pin_sync.sv
module dac_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    output logic pin_low,
    output logic pin_fall
);

    typedef struct packed {
        logic [STAGES-1:0] sync;
        logic              last;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.sync = {s_q.sync[STAGES-2:0], pin_n};
        s_d.last = s_q.sync[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '1;
        else        s_q <= s_d;
    end

    assign pin_low  = ~s_q.sync[STAGES-1];
    assign pin_fall = s_q.last & ~s_q.sync[STAGES-1];

endmodule

// File: rtl/dac_chan_bank.sv
module dac_chan_bank #(
    parameter int NCH = 6,
    parameter int DW  = 12,
    parameter int AW  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [AW-1:0]     addr,
    input  logic [7:0]        wdata,
    input  logic              simul,
    input  logic              load_all,
    output logic [NCH*DW-1:0] hold_flat
);

    localparam int HB     = DW - 8;
    localparam int CW     = AW - 1;
    localparam int WRSPAN = 2 * NCH;

    typedef struct packed {
        logic [NCH-1:0][7:0]    lo;
        logic [NCH-1:0][HB-1:0] hi;
        logic [NCH-1:0][DW-1:0] hold;
    } bank_t;

    bank_t b_d, b_q;
    logic  wr_hit;

    assign wr_hit = wr && (int'(addr) < WRSPAN);

    always_comb begin
        b_d = b_q;
        for (int c = 0; c < NCH; c++) begin
            if (load_all)
                b_d.hold[c] = {b_q.hi[c], b_q.lo[c]};
            if (wr_hit && addr[AW-1:1] == CW'(c)) begin
                if (!addr[0]) begin
                    b_d.lo[c] = wdata;
                end else begin
                    b_d.hi[c] = wdata[HB-1:0];
                    if (!simul)
                        b_d.hold[c] = {wdata[HB-1:0], b_q.lo[c]};
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) b_q <= '0;
        else        b_q <= b_d;
    end

    generate
        for (genvar g = 0; g < NCH; g++) begin : g_out
            assign hold_flat[g*DW +: DW] = b_q.hold[g];
        end
    endgenerate

endmodule

// File: rtl/dac_bank_ctrl.sv
module dac_bank_ctrl
    import dac_ctrl_pkg::*;
#(
    parameter int NCH  = 6,
    parameter int DW   = 12,
    parameter int AW   = 4,
    parameter int SYNC = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AW-1:0]     bus_addr,
    input  logic [7:0]        bus_wdata,
    input  logic              bus_wr,
    input  logic              bus_rd,
    output logic [7:0]        bus_rdata,
    input  logic              ext_n,
    output logic [NCH*DW-1:0] dac_code,
    output logic              irq
);

    localparam logic [DW-1:0] MIDSCALE = DW'(1) << (DW - 1);

    rd_cmd_t          cmd;
    mode_t            m_d, m_q;
    logic             pin_low, pin_fall;
    logic             load_all;
    logic [NCH*DW-1:0] hold_flat;

    dac_rd_decode #(.AW(AW)) u_dec (
        .rd   (bus_rd),
        .addr (bus_addr),
        .cmd  (cmd)
    );

    dac_pin_sync #(.STAGES(SYNC)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_n    (ext_n),
        .pin_low  (pin_low),
        .pin_fall (pin_fall)
    );

    assign load_all = cmd.load_sim | cmd.load_imm | (m_q.trig_en & pin_low);

    dac_chan_bank #(.NCH(NCH), .DW(DW), .AW(AW)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (bus_wr),
        .addr      (bus_addr),
        .wdata     (bus_wdata),
        .simul     (m_q.simul),
        .load_all  (load_all),
        .hold_flat (hold_flat)
    );

    always_comb begin
        m_d = m_q;
        if (cmd.sim_on  | cmd.load_sim) m_d.simul   = 1'b1;
        if (cmd.sim_off | cmd.load_imm) m_d.simul   = 1'b0;
        if (cmd.rstr_on)                m_d.rstr    = 1'b1;
        if (cmd.rstr_off)               m_d.rstr    = 1'b0;
        if (cmd.trig_on)                m_d.trig_en = 1'b1;
        if (cmd.trig_off)               m_d.trig_en = 1'b0;
        if (cmd.irq_en)                 m_d.irq_en  = 1'b1;
        if (cmd.irq_clr) begin
            m_d.irq_en   = 1'b0;
            m_d.irq_flag = 1'b0;
        end else if (pin_fall && m_q.irq_en) begin
            m_d.irq_flag = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_q      <= '0;
            m_q.rstr <= 1'b1;
        end else begin
            m_q <= m_d;
        end
    end

    generate
        for (genvar g = 0; g < NCH; g++) begin : g_drv
            assign dac_code[g*DW +: DW] = m_q.rstr ? MIDSCALE : hold_flat[g*DW +: DW];
        end
    endgenerate

    assign irq       = m_q.irq_flag & m_q.irq_en;
    assign bus_rdata = '0;

endmodule

// File: rtl/dac_bank_ctrl_chk.sv
module dac_bank_ctrl_chk #(
    parameter int NCH = 6,
    parameter int DW  = 12,
    parameter int AW  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [AW-1:0]     bus_addr,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [NCH*DW-1:0] dac_code,
    input logic              irq,
    input logic              load_all,
    input logic              pin_fall
);

    function automatic logic all_mid(input logic [NCH*DW-1:0] v);
        logic ok;
        ok = 1'b1;
        for (int c = 0; c < NCH; c++)
            if (v[c*DW +: DW] != (DW'(1) << (DW - 1))) ok = 1'b0;
        return ok;
    endfunction

    logic rd_quiet;
    assign rd_quiet = bus_rd && (bus_addr == 4'h1 || bus_addr == 4'h7 ||
                      bus_addr == 4'h9 || bus_addr == 4'hB ||
                      bus_addr == 4'hC || bus_addr == 4'hD);

    p_lo_write_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !bus_addr[0] && !bus_rd && !load_all) |=> $stable(dac_code));

    p_policy_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && (bus_addr == 4'h0 || bus_addr == 4'h2) && !bus_wr && !load_all)
        |=> $stable(dac_code));

    p_restrict_mid_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == 4'hE) |=> all_mid(dac_code));

    p_irq_source_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(pin_fall));

    p_irq_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == 4'h4) |=> !irq);

    p_unused_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_quiet && !bus_wr && !load_all && !pin_fall) |=> ($stable(dac_code) && $stable(irq)));

endmodule

bind dac_bank_ctrl dac_bank_ctrl_chk #(.NCH(NCH), .DW(DW), .AW(AW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_addr (bus_addr),
    .bus_wr   (bus_wr),
    .bus_rd   (bus_rd),
    .dac_code (dac_code),
    .irq      (irq),
    .load_all (load_all),
    .pin_fall (pin_fall)
);

// File: tb/sim_dac_bank_ctrl.sv
`timescale 1ns/1ps
module sim_dac_bank_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  addr = '0;
    logic [7:0]  wdata = '0;
    logic        wr = 1'b0;
    logic        rd = 1'b0;
    logic [7:0]  rdata;
    logic        ext_n = 1'b1;
    logic [71:0] code;
    logic        irq;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    dac_bank_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wdata(wdata),
        .bus_wr(wr), .bus_rd(rd), .bus_rdata(rdata), .ext_n(ext_n),
        .dac_code(code), .irq(irq)
    );

    function automatic logic [11:0] cd(input int ch);
        return code[ch*12 +: 12];
    endfunction

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic ticks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bw(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic br(input logic [3:0] a);
        @(negedge clk);
        addr = a; rd = 1'b1;
        #1 chk("R9 rdata", {8'h0, rdata}, 16'h0000);
        @(negedge clk);
        rd = 1'b0;
    endtask

    task automatic t_reset;
        for (int c = 0; c < 6; c++) chk("R1 reset code", {4'h0, cd(c)}, 16'h0800);
        chk("R1 reset irq", {15'h0, irq}, 16'h0);
        chk("R1 reset rdata", {8'h0, rdata}, 16'h0);
        br(4'hF);
        for (int c = 0; c < 6; c++) chk("R5 clear restrict from reset", {4'h0, cd(c)}, 16'h0000);
    endtask

    task automatic t_immediate;
        bw(4'h0, 8'h34);
        chk("R2 low byte alone", {4'h0, cd(0)}, 16'h0000);
        bw(4'h1, 8'h5A);
        chk("R2 high byte update", {4'h0, cd(0)}, 16'h0A34);
        bw(4'hA, 8'hCD);
        bw(4'hB, 8'h07);
        chk("R2 channel 5", {4'h0, cd(5)}, 16'h07CD);
        chk("R2 channel 4 untouched", {4'h0, cd(4)}, 16'h0000);
    endtask

    task automatic t_simul;
        br(4'h0);
        chk("R3 enter simultaneous no change", {4'h0, cd(0)}, 16'h0A34);
        bw(4'h2, 8'h11);
        bw(4'h3, 8'h02);
        chk("R3 write held in simultaneous", {4'h0, cd(1)}, 16'h0000);
        br(4'h2);
        chk("R3 leave without update", {4'h0, cd(1)}, 16'h0000);
        bw(4'h3, 8'h03);
        chk("R3 immediate again", {4'h0, cd(1)}, 16'h0311);
    endtask

    task automatic t_load;
        br(4'h0);
        bw(4'h4, 8'h22); bw(4'h5, 8'h0B);
        bw(4'h8, 8'h44); bw(4'h9, 8'h0C);
        chk("R4 before load", {4'h0, cd(2)}, 16'h0000);
        br(4'h8);
        chk("R4 load ch2", {4'h0, cd(2)}, 16'h0B22);
        chk("R4 load ch4", {4'h0, cd(4)}, 16'h0C44);
        bw(4'h9, 8'h0D);
        chk("R4 still simultaneous", {4'h0, cd(4)}, 16'h0C44);
        br(4'hA);
        chk("R4 load and release", {4'h0, cd(4)}, 16'h0D44);
        bw(4'h9, 8'h0E);
        chk("R4 immediate after release", {4'h0, cd(4)}, 16'h0E44);
    endtask

    task automatic t_restrict;
        br(4'hE);
        for (int c = 0; c < 6; c++) chk("R5 restrict midscale", {4'h0, cd(c)}, 16'h0800);
        bw(4'h1, 8'h01);
        chk("R5 update hidden", {4'h0, cd(0)}, 16'h0800);
        br(4'hF);
        chk("R5 restored ch0", {4'h0, cd(0)}, 16'h0134);
        chk("R5 restored ch1", {4'h0, cd(1)}, 16'h0311);
        chk("R5 restored ch2", {4'h0, cd(2)}, 16'h0B22);
        chk("R5 restored ch4", {4'h0, cd(4)}, 16'h0E44);
        chk("R5 restored ch5", {4'h0, cd(5)}, 16'h07CD);
    endtask

    task automatic t_unused;
        logic [71:0] snap;
        snap = code;
        br(4'h1); br(4'h7); br(4'h9); br(4'hB); br(4'hC); br(4'hD);
        chk("R9 unused reads keep ch0", {4'h0, cd(0)}, {4'h0, snap[11:0]});
        chk("R9 unused reads keep ch5", {4'h0, cd(5)}, {4'h0, snap[71:60]});
        chk("R9 unused reads irq", {15'h0, irq}, 16'h0);
        bw(4'h1, 8'h02);
        chk("R9 policy unchanged by unused reads", {4'h0, cd(0)}, 16'h0234);
        snap = code;
        bw(4'hC, 8'hFF); bw(4'hD, 8'hFF); bw(4'hE, 8'hFF); bw(4'hF, 8'hFF);
        chk("R9 unused writes", code[63:0] == snap[63:0] ? 16'h1 : 16'h0, 16'h1);
        chk("R9 unused writes ch5", {4'h0, cd(5)}, {4'h0, snap[71:60]});
    endtask

    task automatic t_trig;
        br(4'h0);
        bw(4'h6, 8'h66); bw(4'h7, 8'h06);
        @(negedge clk) ext_n = 1'b0;
        ticks(4);
        chk("R6 disabled trigger ignored", {4'h0, cd(3)}, 16'h0000);
        ext_n = 1'b1; ticks(4);
        br(4'h5);
        ext_n = 1'b0;
        ticks(2);
        chk("R6 no copy before third edge", {4'h0, cd(3)}, 16'h0000);
        ticks(1);
        chk("R6 copy at third edge", {4'h0, cd(3)}, 16'h0666);
        bw(4'h7, 8'h09);
        ticks(1);
        chk("R6 level keeps copying", {4'h0, cd(3)}, 16'h0966);
        ext_n = 1'b1; ticks(4);
        br(4'h6);
        bw(4'h7, 8'h0A);
        ext_n = 1'b0; ticks(4);
        chk("R6 trigger disabled again", {4'h0, cd(3)}, 16'h0966);
        ext_n = 1'b1; ticks(4);
        br(4'h2);
        chk("R3 leave keeps ch3", {4'h0, cd(3)}, 16'h0966);
    endtask

    task automatic t_irq;
        br(4'h4);
        ext_n = 1'b0; ticks(4); ext_n = 1'b1; ticks(4);
        chk("R7 edge lost while disabled", {15'h0, irq}, 16'h0);
        br(4'h3);
        chk("R7 enable alone no irq", {15'h0, irq}, 16'h0);
        ext_n = 1'b0;
        ticks(2);
        chk("R7 no irq before third edge", {15'h0, irq}, 16'h0);
        ticks(1);
        chk("R7 irq at third edge", {15'h0, irq}, 16'h1);
        ext_n = 1'b1; ticks(4);
        chk("R7 irq latched", {15'h0, irq}, 16'h1);
        br(4'h4);
        chk("R8 clear", {15'h0, irq}, 16'h0);
        ext_n = 1'b0; ticks(4); ext_n = 1'b1; ticks(4);
        chk("R8 needs re-enable", {15'h0, irq}, 16'h0);
        br(4'h3);
        chk("R8 re-enable no stale flag", {15'h0, irq}, 16'h0);
        ext_n = 1'b0; ticks(4);
        chk("R8 irq after re-enable", {15'h0, irq}, 16'h1);
        ext_n = 1'b1; ticks(4);
        br(4'h4);
        chk("R8 final clear", {15'h0, irq}, 16'h0);
    endtask

    initial begin
        ticks(3);
        rst_n = 1'b1;
        ticks(2);
        t_reset;
        t_immediate;
        t_simul;
        t_load;
        t_restrict;
        t_unused;
        t_trig;
        t_irq;
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule